// File: doc/BRIEF.md
# Framed Serial Control Receiver

This block is a write-only slave that takes control bytes from a host over three wires: a bus clock, a data line and a framing line. A transfer opens when the framing line falls while the bus clock is high and closes when it rises while the bus clock is high. Between those two events the host shifts bytes in, most significant bit first. The first byte is the device address. It must match a fixed pattern in which one bit comes from a strap input and the lowest bit, the write flag, is zero. The slave acknowledges each byte during a ninth clock by pulling the data line low through an open-drain style enable. It hands every byte that follows the address to the core as a one-cycle strobe with the byte value.

All three lines are sampled by a much faster system clock. They pass through a two-flop synchronizer and are then edge-detected in that domain. When the framing line is wired to the data line, the framing rules become the ordinary two-wire start and stop conditions, so the same block also serves as a plain two-wire write slave. A start seen in the middle of a transfer restarts address reception. A wrong address silences the slave until the next start.

Top module: `sctl_rx`

## Requirements
- R1: After reset the acknowledge pull output is 0 and no byte strobe is issued.
- R2: A start is a falling edge of the framing line while the bus clock is high, and a stop is a rising edge of it while the bus clock is high. Framing line edges while the bus clock is low have no effect on a transfer in progress.
- R3: Data is sampled on each rising bus clock edge, eight bits per byte, most significant bit first.
- R4: The address byte expected, from bit 7 down to bit 0, is 1,0,0,0,1,0,S,0, where S is the level of the strap input. When it matches, the slave acknowledges it.
- R5: Any other address byte, including one whose bit 0 (write flag) is 1, gets no acknowledge. No byte strobe and no acknowledge follow until the next start.
- R6: The acknowledge pull turns on at the falling bus clock edge that ends the eighth bit and turns off at the falling edge that ends the ninth clock. It is never on outside that slot.
- R7: Each byte after a matched address is acknowledged and issued as a single-cycle strobe carrying its value, for any number of bytes up to a stop.
- R8: A start seen in the middle of a byte restarts address reception.
- R9: With the framing line tied to the data line, the slave behaves identically as a two-wire slave.
- R10: After a stop the slave ignores clocked bits until the next start, so it acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_clk_i | input | 1 | Raw bus clock line |
| bus_dat_i | input | 1 | Raw bus data line (wired level) |
| bus_frm_i | input | 1 | Raw framing line (may be tied to data) |
| addr_sel_i | input | 1 | Strap that sets the selectable address bit |
| dat_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe, rx_byte_o is new |

## Verification
In two-wire mode the acknowledge pull and framing detection act on the same wire, so the slave's own drive could look like a framing edge. The bench models the wired-AND line and feeds it back to both the data and framing inputs. It drives the pull through complete transfers, a restart in the middle of a byte and a stop, and passes only if no false start or stop shows up as a lost acknowledge or a missing byte. In separate-line mode, framing pulses are applied while the clock is low inside data bytes. These must leave the received values and acknowledges unchanged.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;

  localparam int unsigned LINES_N = 3;
  localparam int unsigned LN_CLK  = 0;
  localparam int unsigned LN_DAT  = 1;
  localparam int unsigned LN_FRM  = 2;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar ln = 0; ln < WIDTH; ln++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[ln]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_o[ln] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s_i,
  input  logic dat_s_i,
  input  logic frm_s_i,
  output logic clk_rise_o,
  output logic clk_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic dat_o
);
  logic clk_p_q;
  logic frm_p_q;
  logic clk_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_p_q <= 1'b1;
      frm_p_q <= 1'b1;
    end else begin
      clk_p_q <= clk_s_i;
      frm_p_q <= frm_s_i;
    end
  end

  always_comb begin
    clk_hi     = clk_s_i & clk_p_q;
    clk_rise_o = clk_s_i & ~clk_p_q;
    clk_fall_o = ~clk_s_i & clk_p_q;
    start_o    = clk_hi & frm_p_q & ~frm_s_i;
    stop_o     = clk_hi & ~frm_p_q & frm_s_i;
    dat_o      = dat_s_i;
  end
endmodule

// File: rtl/sctl_byte_rx.sv
module sctl_byte_rx
  import sctl_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter logic [7:0]  ADDR_BASE = 8'h88,
  parameter int unsigned STRAP_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_rise_i,
  input  logic              clk_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dat_i,
  input  logic              strap_i,
  output logic              pull_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_ARM  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shf_q, shf_d;
  logic              pull_q, pull_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_en;
  logic [BYTE_W-1:0] word_w;
  logic [BYTE_W-1:0] addr_exp;
  logic              active;

  always_comb begin
    addr_exp            = BYTE_W'(ADDR_BASE);
    addr_exp[STRAP_POS] = strap_i;
    word_w              = {shf_q[BYTE_W-2:0], dat_i};
    active              = (st_q == ST_ADDR) || (st_q == ST_DATA);
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    shf_d   = shf_q;
    pull_d  = pull_q;
    vld_d   = 1'b0;
    byte_en = 1'b0;
    if (stop_i) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (start_i) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (active) begin
      if (clk_rise_i && (cnt_q < ACK_ARM)) begin
        shf_d = word_w;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          if (st_q == ST_ADDR) begin
            if (word_w != addr_exp) begin
              st_d = ST_SKIP;
            end
          end else begin
            vld_d   = 1'b1;
            byte_en = 1'b1;
          end
        end
      end else if (clk_fall_i && (cnt_q == ACK_ARM)) begin
        pull_d = 1'b1;
        cnt_d  = ACK_SLOT;
      end else if (clk_fall_i && (cnt_q == ACK_SLOT)) begin
        pull_d = 1'b0;
        cnt_d  = '0;
        st_d   = ST_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      shf_q  <= '0;
      pull_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      shf_q  <= shf_d;
      pull_q <= pull_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= word_w;
    end
  end

  assign pull_o  = pull_q;
  assign byte_o  = byte_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
  import sctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_W      = 8,
  parameter logic [7:0]  ADDR_BASE   = 8'h88,
  parameter int unsigned STRAP_POS   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic              bus_frm_i,
  input  logic              addr_sel_i,
  output logic              dat_pull_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic [LINES_N-1:0] raw_w;
  logic [LINES_N-1:0] syn_w;
  logic               bclk_rise;
  logic               bclk_fall;
  logic               frm_start;
  logic               frm_stop;
  logic               dat_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    raw_w         = '1;
    raw_w[LN_CLK] = bus_clk_i;
    raw_w[LN_DAT] = bus_dat_i;
    raw_w[LN_FRM] = bus_frm_i;
  end

  sctl_sync #(
    .WIDTH  (LINES_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (raw_w),
    .q_o   (syn_w)
  );

  sctl_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clk_s_i    (syn_w[LN_CLK]),
    .dat_s_i    (syn_w[LN_DAT]),
    .frm_s_i    (syn_w[LN_FRM]),
    .clk_rise_o (bclk_rise),
    .clk_fall_o (bclk_fall),
    .start_o    (frm_start),
    .stop_o     (frm_stop),
    .dat_o      (dat_w)
  );

  sctl_byte_rx #(
    .BYTE_W    (BYTE_W),
    .ADDR_BASE (ADDR_BASE),
    .STRAP_POS (STRAP_POS)
  ) u_byte (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clk_rise_i (bclk_rise),
    .clk_fall_i (bclk_fall),
    .start_i    (frm_start),
    .stop_i     (frm_stop),
    .dat_i      (dat_w),
    .strap_i    (addr_sel_i),
    .pull_o     (dat_pull_o),
    .byte_o     (rx_byte_o),
    .valid_o    (rx_valid_o)
  );
endmodule

// File: rtl/sctl_rx_chk.sv
module sctl_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic frm_start,
  input logic frm_stop,
  input logic bclk_fall,
  input logic dat_pull_o,
  input logic rx_valid_o
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R7
  AST_PULL_ON_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_pull_o) |-> $past(bclk_fall)); // R6
  AST_PULL_OFF_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_pull_o) |-> $past(bclk_fall || frm_start || frm_stop)); // R6
  AST_STROBE_NOT_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !dat_pull_o); // R6
  AST_RESTART_DROPS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !dat_pull_o && !rx_valid_o); // R8
  AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stop |=> !dat_pull_o && !rx_valid_o); // R2
endmodule

bind sctl_rx sctl_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_start  (frm_start),
  .frm_stop   (frm_stop),
  .bclk_fall  (bclk_fall),
  .dat_pull_o (dat_pull_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/sctl_rx_bench.sv
`timescale 1ns/1ps
module sctl_rx_bench;
  logic       clk;
  logic       rst_n;
  logic       h_clk, h_dat, h_frm;
  logic       tied;
  logic       strap;
  logic       line_dat, line_frm;
  logic       dat_pull_o;
  logic [7:0] rx_byte_o;
  logic       rx_valid_o;

  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [7:0] cap [16];
  int         ncap = 0;

  assign line_dat = h_dat & ~dat_pull_o;
  assign line_frm = tied ? line_dat : h_frm;

  sctl_rx u_sctl_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_clk_i  (h_clk),
    .bus_dat_i  (line_dat),
    .bus_frm_i  (line_frm),
    .addr_sel_i (strap),
    .dat_pull_o (dat_pull_o),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid_o) begin
      cap[ncap % 16] = rx_byte_o;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    h_dat = 1'b1; h_frm = 1'b1;
    wt(4); h_clk = 1'b1; wt(8);
    if (tied) h_dat = 1'b0; else h_frm = 1'b0;
    wt(8); h_clk = 1'b0; wt(2); h_frm = 1'b1;
  endtask

  task automatic bus_stop();
    wt(2); h_dat = 1'b0; if (!tied) h_frm = 1'b0;
    wt(6); h_clk = 1'b1; wt(8);
    if (tied) h_dat = 1'b1; else h_frm = 1'b1;
    wt(8);
  endtask

  task automatic bus_bit(input logic b, input bit glitch);
    wt(2); h_dat = b;
    if (glitch && !tied) h_frm = 1'b0;
    wt(2); h_frm = 1'b1;
    wt(4); h_clk = 1'b1; wt(8); h_clk = 1'b0;
  endtask

  task automatic bus_byte(input logic [7:0] v, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i], glitch);
    wt(2); h_dat = 1'b1; wt(6); h_clk = 1'b1; wt(4);
    ack = ~line_dat;
    wt(4); h_clk = 1'b0; wt(6);
    chk(dat_pull_o == 1'b0, "R6 pull released after ninth clock", dat_pull_o, 0);
  endtask

  function automatic logic [7:0] good_addr(input logic s);
    return 8'h88 | {6'd0, s, 1'b0};
  endfunction

  initial begin
    bit ack;
    int base;
    logic [7:0] v;
    rst_n = 1'b0; h_clk = 1'b1; h_dat = 1'b1; h_frm = 1'b1; tied = 1'b0; strap = 1'b0;
    wt(6);
    chk(dat_pull_o == 1'b0, "R1 pull at reset", dat_pull_o, 0);
    chk(rx_valid_o == 1'b0, "R1 strobe at reset", rx_valid_o, 0);
    rst_n = 1'b1;
    wt(10);
    chk(ncap == 0 && dat_pull_o == 1'b0, "R1 quiet after reset", ncap, 0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      tied  = cfg[1];
      strap = cfg[0];
      wt(10);
      // R4 R7 R3 R9: matched address then several data bytes
      bus_start();
      bus_byte(good_addr(strap), 1'b0, ack);
      chk(ack, "R4 R9 address acknowledged", ack, 1);
      for (int k = 0; k < 4; k++) begin
        base = ncap;
        v = 8'hA5 ^ 8'(k * 37) ^ 8'(cfg * 8'h51);
        bus_byte(v, (k == 1), ack);
        chk(ack, "R7 data byte acknowledged", ack, 1);
        chk(ncap == base + 1, "R7 one strobe per byte", ncap - base, 1);
        chk(cap[base % 16] == v, "R3 R2 byte value", cap[base % 16], v);
      end
      bus_stop();
      // R10: bits after stop ignored
      base = ncap;
      bus_byte(good_addr(strap), 1'b0, ack);
      chk(!ack, "R10 no ack after stop", ack, 0);
      bus_byte(8'h3C, 1'b0, ack);
      chk(!ack && ncap == base, "R10 nothing after stop", ncap - base, 0);
      bus_stop();
      // R5: every single-bit address error, including the write flag
      for (int b = 0; b < 8; b++) begin
        bus_start();
        base = ncap;
        bus_byte(good_addr(strap) ^ 8'(1 << b), 1'b0, ack);
        chk(!ack, "R5 wrong address not acknowledged", ack, 0);
        bus_byte(8'h5A, 1'b0, ack);
        chk(!ack && ncap == base, "R5 silent after mismatch", ncap - base, 0);
        bus_stop();
      end
      // R8: restart in the middle of a data byte
      bus_start();
      base = ncap;
      bus_byte(good_addr(strap), 1'b0, ack);
      bus_byte(8'h81, 1'b0, ack);
      for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0);
      bus_start();
      bus_byte(good_addr(strap), 1'b0, ack);
      chk(ack, "R8 address after restart acknowledged", ack, 1);
      bus_byte(8'h7E, 1'b0, ack);
      chk(ack && ncap == base + 2, "R8 bytes around restart", ncap - base, 2);
      chk(cap[(base + 1) % 16] == 8'h7E, "R8 byte after restart", cap[(base + 1) % 16], 8'h7E);
      bus_stop();
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule